// File: doc/BRIEF.md
# Radio-Activity Output Word Selector

This block drives a bank of general-purpose output lines, such as indicator lights or front-end switch controls, from a small register bank. Two inputs report whether the receive path and the transmit path are busy. Together they give one of four radio conditions: quiet, receive alone, transmit alone, or both at once. Software writes one output word for each condition.

On every clock the block picks the word for the present condition. A per-bit select mask decides, bit by bit, whether that line follows the condition word or a value that software writes by hand. The result is registered before it reaches the pins.

Software programs the bank through a plain write strobe with an address and a data word. The bank has no readback path and no pin-direction control. A common setup drives three lights. With bits 0 to 2 of the mask set, the quiet word is zero, the transmit-alone word sets bit 1, the both-busy word sets bits 1 and 2, and the receive-alone word sets either bit 2 or bit 0, depending on which antenna is in use.

Top module: `atr_out_bank`

## Requirements
- R1: While `rst` is high, all six registers clear to zero, and `pins` reads zero on the clock after each reset edge.
- R2: When `rx_active` and `tx_active` are both low, the condition word is the register at offset 0.
- R3: When `rx_active` is high and `tx_active` is low, the condition word is the register at offset 1.
- R4: When `tx_active` is high and `rx_active` is low, the condition word is the register at offset 2.
- R5: When both `rx_active` and `tx_active` are high, the condition word is the register at offset 3.
- R6: The register at offset 4 is the select mask and the register at offset 5 is the hand-set value. Output bit i takes bit i of the condition word when mask bit i is 1, and bit i of the hand-set value when mask bit i is 0.
- R7: `pins` is registered. A change on `rx_active` or `tx_active` sampled at one rising edge appears on `pins` after that same edge and not before it.
- R8: A write sampled at an edge updates its register at that edge. The output computed at that same edge still uses the old contents, and the new contents reach `pins` one edge later. This also holds when the condition changes in the same cycle as the write.
- R9: Writes to offsets 6 and 7 change no register, so `pins` behaves exactly as if the write had not occurred.
- R10: Any interleaving of writes to offsets 0 to 5 and condition changes produces, at every edge, the output that R2 to R6 give from the register contents and inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register offset (0-5 mapped, 6-7 unused) |
| wr_data | input | OUT_W | Write data |
| rx_active | input | 1 | Receive path busy |
| tx_active | input | 1 | Transmit path busy |
| pins | output | OUT_W | Registered output word |

## Verification
The assertions assume that `rx_active`, `tx_active` and the write port are synchronous to `clk` and stable around each rising edge. They also assume that `rst` is held high from time zero through at least one edge. The bench meets these assumptions by changing every input only on falling edges and by starting in reset. Its reference model applies the condition selection and the per-bit merge to a behavioural copy of the register contents, one edge at a time. The stimulus covers each condition under several mask patterns, writes that coincide with condition changes, writes to the unused offsets, and a long random interleaving.

// File: rtl/atr_pkg.sv
package atr_pkg;
  localparam int NUM_REGS = 6;
  localparam int ADDR_W   = 3;

  // Encoding equals {tx, rx}; value doubles as the word's register offset.
  typedef enum logic [1:0] {
    RADIO_IDLE = 2'd0,
    RADIO_RX   = 2'd1,
    RADIO_TX   = 2'd2,
    RADIO_FDX  = 2'd3
  } radio_state_e;

  localparam logic [ADDR_W-1:0] SLOT_IDLE   = 3'd0;
  localparam logic [ADDR_W-1:0] SLOT_RX     = 3'd1;
  localparam logic [ADDR_W-1:0] SLOT_TX     = 3'd2;
  localparam logic [ADDR_W-1:0] SLOT_FDX    = 3'd3;
  localparam logic [ADDR_W-1:0] SLOT_MASK   = 3'd4;
  localparam logic [ADDR_W-1:0] SLOT_MANUAL = 3'd5;
endpackage

// File: rtl/atr_regfile.sv
module atr_regfile
  import atr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [W-1:0]                   wr_data,
  output logic [NUM_REGS-1:0][W-1:0]     regs
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[k] <= '0;
      end else if (wr_en && (wr_addr == ADDR_W'(k))) begin
        regs[k] <= wr_data;
      end
    end
  end

  // R9
  unmapped_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_addr >= ADDR_W'(NUM_REGS))) |=> $stable(regs));

  // R8
  manual_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_addr == SLOT_MANUAL)) |=> (regs[SLOT_MANUAL] == $past(wr_data)));

  // R8
  mask_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_addr == SLOT_MASK)) |=> (regs[SLOT_MASK] == $past(wr_data)));
endmodule

// File: rtl/atr_state_decode.sv
module atr_state_decode
  import atr_pkg::*;
(
  input  logic         rx_active,
  input  logic         tx_active,
  output radio_state_e state
);
  always_comb begin
    unique case ({tx_active, rx_active})
      2'b01:   state = RADIO_RX;
      2'b10:   state = RADIO_TX;
      2'b11:   state = RADIO_FDX;
      default: state = RADIO_IDLE;
    endcase
  end
endmodule

// File: rtl/atr_bit_mux.sv
module atr_bit_mux #(
  parameter int W = 8
) (
  input  logic [W-1:0] cond_word,
  input  logic [W-1:0] hand_word,
  input  logic [W-1:0] sel_mask,
  output logic [W-1:0] merged
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign merged[i] = sel_mask[i] ? cond_word[i] : hand_word[i];
  end
endmodule

// File: rtl/atr_out_bank.sv
module atr_out_bank
  import atr_pkg::*;
#(
  parameter int OUT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [OUT_W-1:0]  wr_data,
  input  logic              rx_active,
  input  logic              tx_active,
  output logic [OUT_W-1:0]  pins
);
  logic [NUM_REGS-1:0][OUT_W-1:0] regs;
  radio_state_e                   state;
  logic [OUT_W-1:0]               cond_word;
  logic [OUT_W-1:0]               merged;

  atr_regfile #(.W(OUT_W)) i_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .regs(regs)
  );

  atr_state_decode i_dec (
    .rx_active(rx_active), .tx_active(tx_active), .state(state)
  );

  always_comb begin
    unique case (state)
      RADIO_RX:  cond_word = regs[SLOT_RX];
      RADIO_TX:  cond_word = regs[SLOT_TX];
      RADIO_FDX: cond_word = regs[SLOT_FDX];
      default:   cond_word = regs[SLOT_IDLE];
    endcase
  end

  atr_bit_mux #(.W(OUT_W)) i_mux (
    .cond_word(cond_word), .hand_word(regs[SLOT_MANUAL]),
    .sel_mask(regs[SLOT_MASK]), .merged(merged)
  );

  always_ff @(posedge clk) begin
    if (rst) pins <= '0;
    else     pins <= merged;
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk) rst |=> (pins == '0));

  // R2
  idle_word_chk: assert property (@(posedge clk) disable iff (rst)
    (!rx_active && !tx_active && (regs[SLOT_MASK] == '1)) |=> (pins == $past(regs[SLOT_IDLE])));

  // R3
  rx_word_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_active && !tx_active && (regs[SLOT_MASK] == '1)) |=> (pins == $past(regs[SLOT_RX])));

  // R4
  tx_word_chk: assert property (@(posedge clk) disable iff (rst)
    (!rx_active && tx_active && (regs[SLOT_MASK] == '1)) |=> (pins == $past(regs[SLOT_TX])));

  // R5
  fdx_word_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_active && tx_active && (regs[SLOT_MASK] == '1)) |=> (pins == $past(regs[SLOT_FDX])));

  // R6
  manual_only_chk: assert property (@(posedge clk) disable iff (rst)
    (regs[SLOT_MASK] == '0) |=> (pins == $past(regs[SLOT_MANUAL])));
endmodule

// File: tb/test_atr_out_bank.sv
module test_atr_out_bank;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic         rx_active = 1'b0;
  logic         tx_active = 1'b0;
  logic [W-1:0] pins;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit started = 1'b0;
  string cur_req = "R1";

  logic [W-1:0] m_reg [6];
  logic [W-1:0] exp_pins = '0;

  always #5 clk = ~clk;

  atr_out_bank #(.OUT_W(W)) i_atr_out_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rx_active(rx_active), .tx_active(tx_active), .pins(pins)
  );

  // Behavioural reference: output from pre-edge contents, then apply write.
  always @(posedge clk) begin
    int idx;
    started = 1'b1;
    if (rst) begin
      for (int k = 0; k < 6; k++) m_reg[k] = '0;
      exp_pins = '0;
    end else begin
      if (rx_active && tx_active) idx = 3;
      else if (tx_active)         idx = 2;
      else if (rx_active)         idx = 1;
      else                        idx = 0;
      exp_pins = (m_reg[idx] & m_reg[4]) | (m_reg[5] & ~m_reg[4]);
      if (wr_en && wr_addr < 3'd6) m_reg[wr_addr] = wr_data;
    end
  end

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: pins=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (started) check(cur_req, pins, exp_pins);
    if (cyc > 20000) begin
      bad++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic cond(logic rx, logic tx, int n);
    rx_active = rx; tx_active = tx;
    repeat (n) tick();
  endtask

  initial begin
    cur_req = "R1";
    repeat (3) tick();
    check("R1", pins, '0);
    rst = 1'b0;
    cur_req = "R10";
    wr(3'd0, 8'h11); wr(3'd1, 8'h22); wr(3'd2, 8'h44); wr(3'd3, 8'h88);
    wr(3'd4, 8'hFF); wr(3'd5, 8'h5A);
    tick();
    cur_req = "R2"; cond(0, 0, 2); check("R2", pins, 8'h11);
    cur_req = "R3"; cond(1, 0, 2); check("R3", pins, 8'h22);
    cur_req = "R4"; cond(0, 1, 2); check("R4", pins, 8'h44);
    cur_req = "R5"; cond(1, 1, 2); check("R5", pins, 8'h88);
    cur_req = "R6";
    wr(3'd4, 8'h0F); tick();
    cond(1, 1, 2); check("R6", pins, 8'h58);
    cond(1, 0, 2); check("R6", pins, 8'h52);
    wr(3'd4, 8'h00); tick();
    cond(0, 1, 2); check("R6", pins, 8'h5A);
    cur_req = "R7";
    wr(3'd4, 8'hFF);
    cond(0, 0, 2);
    rx_active = 1'b1;
    tick(); check("R7", pins, 8'h22);
    tx_active = 1'b1;
    tick(); check("R7", pins, 8'h88);
    cur_req = "R8";
    cond(1, 0, 2);
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'hC3; rx_active = 1'b0;
    tick(); wr_en = 1'b0;
    check("R8", pins, 8'h11);
    tick(); check("R8", pins, 8'hC3);
    cur_req = "R9";
    wr(3'd6, 8'hFF); wr(3'd7, 8'h00);
    cond(0, 0, 2); check("R9", pins, 8'hC3);
    cond(1, 0, 2); check("R9", pins, 8'h22);
    cond(0, 1, 2); check("R9", pins, 8'h44);
    cond(1, 1, 2); check("R9", pins, 8'h88);
    cur_req = "R10";
    for (int n = 0; n < 2000; n++) begin
      rx_active = 1'($urandom);
      tx_active = 1'($urandom);
      wr_en     = 1'($urandom);
      wr_addr   = 3'($urandom);
      wr_data   = 8'($urandom);
      tick();
    end
    wr_en = 1'b0;
    tick();
    cur_req = "R1";
    rst = 1'b1;
    tick(); tick();
    check("R1", pins, '0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule